// File: doc/BRIEF.md
# Dual-Channel Serial Converter Interface with Chip-Select Power Control

This block is a device-side model of the digital interface of a dual-channel 12-bit serial converter. Two parallel 12-bit sample inputs stand in for the converters. Each one is serialised onto its own data line, and each line has its own output-enable. A falling edge on the active-low chip select starts a frame. The design counts falling edges of the serial clock from that point. Data bits change on those edges, most significant bit first.

The same chip select also picks the power state. When chip select rises, the count of serial-clock falling edges seen so far decides the next state: normal, partial power-down or full power-down. A short glitch on chip select changes nothing. A release in the early window drops the device one power level. A conversion that is held long enough wakes the device from either power-down state. The frame that performs the wake is flagged as carrying invalid data.

If chip select stays low past the first result and its trailing zeros, each line goes on to carry the other channel's result. A line releases itself after 32 falling edges. All inputs are sampled on the system clock. Serial clock and chip select are treated as slow, synchronous level signals.

Top module: `adcif_top`

## Requirements
- R1: After reset the power state reads 0 (normal), both output enables are low and the invalid-data flag is low. Power-state encoding: 0 normal, 1 partial power-down, 2 full power-down.
- R2: Each frame follows a fixed bit order. Data line A carries two zeros, then the channel A sample (MSB first), then four zeros, then the channel B sample, then two zeros. Data line B carries the same pattern with the two channels swapped. Both samples are captured when chip select falls. Bit 0 of the pattern is driven as soon as the frame starts. Bit k is driven after the k-th serial-clock falling edge.
- R3: A line's output enable is high from the chip-select falling edge until whichever comes first: chip select rises, or the 32nd serial-clock falling edge occurs. Further falling edges while chip select stays low leave the enable low.
- R4: In normal state, a release after fewer than 2 falling edges leaves the state normal.
- R5: In normal state, a release after 2 to 9 falling edges moves to partial power-down.
- R6: In normal state, a release after 10 or more falling edges leaves the state normal. A release before the 14th edge still turns the outputs off.
- R7: In partial power-down, a release after fewer than 2 falling edges leaves the state unchanged.
- R8: In partial power-down, a release after 2 to 9 falling edges moves to full power-down.
- R9: In either power-down state, the 10th falling edge of a frame with chip select still low switches the state to normal in the same cycle.
- R10: In full power-down, any release before the 10th falling edge keeps full power-down.
- R11: The invalid-data flag changes only at a chip-select falling edge. It is set for a frame that began in a power-down state and cleared for a frame that began in normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select: frames data and selects power state |
| sclk | input | 1 | Serial clock, sampled on clk |
| chan_a | input | 12 | Channel A sample value |
| chan_b | input | 12 | Channel B sample value |
| sdo_a | output | 1 | Serial data line A |
| sdo_a_oe | output | 1 | Drive enable for line A (low means three-state) |
| sdo_b | output | 1 | Serial data line B |
| sdo_b_oe | output | 1 | Drive enable for line B |
| pwr_state | output | 2 | Current power state |
| data_invalid | output | 1 | Current frame carries no valid conversion |

## Verification
The bench walks the power states through releases at the window boundaries: 0 and 1 edges, 2, 9, 10, 12 and 20. A design that gets a boundary off by one lands in the wrong state. That error shows up immediately on the state output and in every later frame. Full-length frames and a frame that idles 34 edges check the crossing from the own result to the other channel's result. They also check that the line turns off by itself on the 32nd edge; a design that wraps or keeps shifting would drive stale bits. The wake frames from both power-down states check that the state returns to normal exactly on the 10th edge. They also check that the invalid flag covers only that frame and is clear on the next one.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int RES_W        = 12;
    localparam int PAD_W        = 2;
    localparam int FRAME_EDGES  = 2 * (RES_W + 2 * PAD_W);
    localparam int GLITCH_EDGES = 2;
    localparam int WAKE_EDGES   = 10;
    localparam int CNT_W        = $clog2(FRAME_EDGES + 1);

    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'd0,
        PWR_PARTIAL = 2'd1,
        PWR_FULL    = 2'd2
    } pwr_e;

    typedef struct packed {
        logic start;   // chip select fell
        logic rel;     // chip select rose during a frame
        logic fall;    // counted serial-clock falling edge
    } frame_ev_t;

    // Power state chosen by a chip-select release after n falling edges.
    function automatic pwr_e pwr_after_release(pwr_e cur, logic [CNT_W-1:0] n);
        pwr_e nxt;
        nxt = cur;
        if (int'(n) >= GLITCH_EDGES && int'(n) < WAKE_EDGES) begin
            case (cur)
                PWR_NORMAL:  nxt = PWR_PARTIAL;
                PWR_PARTIAL: nxt = PWR_FULL;
                default:     nxt = PWR_FULL;
            endcase
        end
        return nxt;
    endfunction

    // Serial pattern: pad, own result, pad, pad, other result, pad.
    function automatic logic [FRAME_EDGES-1:0] build_word(logic [RES_W-1:0] own,
                                                         logic [RES_W-1:0] other);
        return {{PAD_W{1'b0}}, own, {(2 * PAD_W){1'b0}}, other, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/adcif_frame_ctr.sv
module adcif_frame_ctr
    import adcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    output frame_ev_t        ev,
    output logic             active,
    output logic [CNT_W-1:0] cnt
);
    logic cs_q;
    logic sclk_q;

    always_comb begin
        ev.start = cs_q & ~cs_n;
        ev.rel   = ~cs_q & cs_n & active;
        ev.fall  = sclk_q & ~sclk & ~cs_n & active & (cnt < CNT_W'(FRAME_EDGES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
            active <= 1'b0;
            cnt    <= '0;
        end else begin
            cs_q   <= cs_n;
            sclk_q <= sclk;
            if (ev.start) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (ev.rel) begin
                active <= 1'b0;
            end else if (ev.fall) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_EDGES)); // R3

    AST_IDLE_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
        ev.rel |=> !active); // R3

endmodule

// File: rtl/adcif_pwr_fsm.sv
module adcif_pwr_fsm
    import adcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frame_ev_t        ev,
    input  logic [CNT_W-1:0] cnt,
    output pwr_e             pwr,
    output logic             invalid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr     <= PWR_NORMAL;
            invalid <= 1'b0;
        end else begin
            if (ev.start) begin
                invalid <= (pwr != PWR_NORMAL);
            end
            if (ev.fall && cnt == CNT_W'(WAKE_EDGES - 1) && pwr != PWR_NORMAL) begin
                pwr <= PWR_NORMAL;
            end else if (ev.rel) begin
                pwr <= pwr_after_release(pwr, cnt);
            end
        end
    end

    AST_GLITCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev.rel && cnt < CNT_W'(GLITCH_EDGES)) |=> pwr == $past(pwr)); // R4 R7

    AST_NO_NORMAL_TO_FULL: assert property (@(posedge clk) disable iff (rst)
        (pwr == PWR_NORMAL) |=> pwr != PWR_FULL); // R5

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (pwr == PWR_FULL && ev.rel && cnt < CNT_W'(WAKE_EDGES)) |=> pwr == PWR_FULL); // R10

    AST_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ev.start |=> $stable(invalid)); // R11

endmodule

// File: rtl/adcif_lane.sv
module adcif_lane
    import adcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frame_ev_t        ev,
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic [RES_W-1:0] own,
    input  logic [RES_W-1:0] other,
    output logic             sdo,
    output logic             sdo_oe
);
    logic [FRAME_EDGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (ev.start) begin
            sh <= build_word(own, other);
        end else if (ev.fall) begin
            sh <= {sh[FRAME_EDGES-2:0], 1'b0};
        end
    end

    assign sdo    = sh[FRAME_EDGES-1];
    assign sdo_oe = active & (cnt < CNT_W'(FRAME_EDGES));

    AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sdo); // R2

    AST_LAST_EDGE_OFF: assert property (@(posedge clk) disable iff (rst)
        (ev.fall && cnt == CNT_W'(FRAME_EDGES - 1)) |=> !sdo_oe); // R3

endmodule

// File: rtl/adcif_top.sv
module adcif_top
    import adcif_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] chan_a,
    input  logic [RES_W-1:0] chan_b,
    output logic             sdo_a,
    output logic             sdo_a_oe,
    output logic             sdo_b,
    output logic             sdo_b_oe,
    output logic [1:0]       pwr_state,
    output logic             data_invalid
);
    localparam int LANES = 2;

    frame_ev_t        ev;
    logic             active;
    logic [CNT_W-1:0] cnt;
    pwr_e             pwr;
    logic [LANES-1:0] sdo_v;
    logic [LANES-1:0] oe_v;
    logic [RES_W-1:0] samp [LANES];

    assign samp[0] = chan_a;
    assign samp[1] = chan_b;

    adcif_frame_ctr u_ctr (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .ev     (ev),
        .active (active),
        .cnt    (cnt)
    );

    adcif_pwr_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .cnt     (cnt),
        .pwr     (pwr),
        .invalid (data_invalid)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        adcif_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .ev     (ev),
            .active (active),
            .cnt    (cnt),
            .own    (samp[i]),
            .other  (samp[LANES-1-i]),
            .sdo    (sdo_v[i]),
            .sdo_oe (oe_v[i])
        );
    end

    assign sdo_a     = sdo_v[0];
    assign sdo_b     = sdo_v[1];
    assign sdo_a_oe  = oe_v[0];
    assign sdo_b_oe  = oe_v[1];
    assign pwr_state = pwr;

    AST_CS_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> (!sdo_a_oe && !sdo_b_oe)); // R3

    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        sdo_a_oe == sdo_b_oe); // R3

endmodule

// File: tb/sim_adcif_top.sv
module sim_adcif_top;

    typedef struct {
        logic  a;
        logic  b;
        logic  oe;
        logic  chk_bits;
        logic [1:0] pwr;
        logic  inval;
        string rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] chan_a = '0;
    logic [11:0] chan_b = '0;
    logic        sdo_a, sdo_a_oe, sdo_b, sdo_b_oe, data_invalid;
    logic [1:0]  pwr_state;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [1:0] m_pwr = 2'd0;
    logic m_inval = 1'b0;
    exp_t q[$];
    event chk_ev;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    adcif_top u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk),
        .chan_a(chan_a), .chan_b(chan_b),
        .sdo_a(sdo_a), .sdo_a_oe(sdo_a_oe), .sdo_b(sdo_b), .sdo_b_oe(sdo_b_oe),
        .pwr_state(pwr_state), .data_invalid(data_invalid)
    );

    task automatic cmp(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Monitor: pops the next expected item when the driver signals a sample point.
    initial begin
        forever begin
            @(chk_ev);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.rq, "oe_a", int'(sdo_a_oe), int'(e.oe));
                cmp(e.rq, "oe_b", int'(sdo_b_oe), int'(e.oe));
                cmp(e.rq, "pwr", int'(pwr_state), int'(e.pwr));
                cmp(e.rq, "invalid", int'(data_invalid), int'(e.inval));
                if (e.chk_bits) begin
                    cmp(e.rq, "sdo_a", int'(sdo_a), int'(e.a));
                    cmp(e.rq, "sdo_b", int'(sdo_b), int'(e.b));
                end
            end
        end
    end

    task automatic expect_now(logic a, logic b, logic oe, logic chk, string rq);
        exp_t e;
        e.a = a; e.b = b; e.oe = oe; e.chk_bits = chk;
        e.pwr = m_pwr; e.inval = m_inval; e.rq = rq;
        q.push_back(e);
        ->chk_ev;
    endtask

    // Driver: one chip-select frame with n serial-clock falling edges.
    task automatic run_frame(int n, logic [11:0] a, logic [11:0] b, string rq);
        logic [31:0] wa, wb;
        wa = {2'b00, a, 4'b0000, b, 2'b00};
        wb = {2'b00, b, 4'b0000, a, 2'b00};
        chan_a = a;
        chan_b = b;
        cs_n = 1'b0;
        m_inval = (m_pwr != 2'd0);                 // R11
        @(negedge clk);
        expect_now(wa[31], wb[31], 1'b1, 1'b1, rq); // R2 first bit
        for (int k = 1; k <= n; k++) begin
            sclk = 1'b0;
            @(negedge clk);
            if (k == 10 && m_pwr != 2'd0) m_pwr = 2'd0; // R9
            if (k < 32) expect_now(wa[31-k], wb[31-k], 1'b1, 1'b1, rq);
            else        expect_now(1'b0, 1'b0, 1'b0, 1'b0, rq); // R3
            sclk = 1'b1;
            @(negedge clk);
        end
        cs_n = 1'b1;
        if (n >= 2 && n < 10) begin
            case (m_pwr)
                2'd0:    m_pwr = 2'd1;  // R5
                default: m_pwr = 2'd2;  // R8 R10
            endcase
        end
        @(negedge clk);
        expect_now(1'b0, 1'b0, 1'b0, 1'b0, rq);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        run_frame(32, 12'hABC, 12'h123, "R2");
        run_frame(34, 12'h5A5, 12'hF0F, "R3");
        run_frame(1,  12'h111, 12'h222, "R4");
        run_frame(0,  12'h333, 12'h444, "R4");
        run_frame(12, 12'h777, 12'h888, "R6");
        run_frame(10, 12'h999, 12'h000, "R6");
        run_frame(2,  12'hFFF, 12'h001, "R5");
        run_frame(1,  12'h002, 12'h003, "R7");
        run_frame(12, 12'h804, 12'h405, "R9");
        run_frame(16, 12'hC3C, 12'h3C3, "R11");
        run_frame(9,  12'h010, 12'h020, "R5");
        run_frame(3,  12'h030, 12'h040, "R8");
        run_frame(0,  12'h050, 12'h060, "R10");
        run_frame(9,  12'h070, 12'h080, "R10");
        run_frame(20, 12'h9A5, 12'h65B, "R9");
        run_frame(32, 12'h1E7, 12'hE18, "R11");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule